// File: doc/BRIEF.md
# Host Bus to Shared-Pin RAM Bridge

This block connects a conventional parallel host bus, with separate address and write-data buses, read and write strobes, a chip select and a wait output, to a small RAM port whose eight pins carry address and data in turn. A two-bit mode code says what the shared pins hold. A port clock pulse commits each transfer at its rising edge.

When the host starts an access, the bridge raises wait in the same cycle and captures the request. It runs an address phase and then a data phase, each two system cycles long: one setup cycle with the port clock low, then one strobe cycle with the port clock high. After the data phase it drops wait for one release cycle, and the host completes the access in that cycle. The shared pins come out as an output value, an output enable and a resolved input, so that the bidirectional pad can be built at chip level.

Top module: `mxb_bridge`

## Requirements
- R1: While reset is high, and in the first cycle after it, the port mode is 00 (idle), the pin output enable is low, the port clock is low and the read-data output is zero. Reset during an access abandons it, and after reset the bridge is idle with wait low.
- R2: An access begins in a cycle when chip select is high and read or write is high. Wait is high in that same cycle and in the four cycles after it. Wait is low in the sixth cycle, the release cycle. During any cycle in which the mode is not 00, wait is high.
- R3: The address phase comes before the data phase. It drives mode 01, enables the pins with the captured address, and gives exactly one port clock high cycle, which follows one setup cycle.
- R4: When write is high, the data phase drives mode 11 and enables the pins with the captured write data for one setup cycle and one port clock high cycle.
- R5: When write is low, the data phase drives mode 10 with the pins released. The value on the pins is captured at the system clock edge that ends the port clock high cycle. It appears on the read-data output in the release cycle and stays there until the next read completes. Write accesses leave it unchanged.
- R6: With chip select low, read and write have no effect: wait stays low and no port clock pulse occurs.
- R7: Changes to the host address, write data, read and write inputs while wait is high have no effect on the access in progress.
- R8: The port clock is never high for two cycles in a row. It is high only while the mode is not 00. The mode and the pin output value do not change across the cycle in which the port clock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs | input | 1 | Host chip select |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe (wins if both are high) |
| h_addr | input | BUS_W | Host address |
| h_wdata | input | BUS_W | Host write data |
| h_rdata | output | BUS_W | Data returned by the last completed read |
| h_wait | output | 1 | Stall request to the host |
| p_ad_out | output | BUS_W | Value driven onto the shared pins |
| p_ad_oe | output | 1 | Output enable for the shared pins |
| p_ad_in | input | BUS_W | Resolved value on the shared pins |
| p_mode | output | 2 | Port mode: 00 idle, 01 address, 10 read, 11 write |
| p_clk | output | 1 | Port clock; transfers are committed on its rising edge |

## Verification
A wrong sequencer state shows up at once on the port pins. A pulse may come in the wrong mode, the pins may be enabled during a read, or two strobe cycles may run back to back. The RAM-side monitor catches each of these at the very port clock rise where it happens. A corrupted captured request shows up at the address or write-data strobe of the same access. A bad read capture shows up in the release cycle, which is five cycles after the access starts, when the scoreboard compares the returned byte against its shadow memory. A wrong wait duration is caught by counting stall cycles on every access.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    parameter int unsigned MXB_BUS_W = 8;

    // Port mode codes presented on the two mode pins
    typedef enum logic [1:0] {
        PM_IDLE  = 2'b00,
        PM_ADDR  = 2'b01,
        PM_READ  = 2'b10,
        PM_WRITE = 2'b11
    } pmode_e;

    // Sequencer steps: each phase is a setup cycle then a strobe cycle
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_A_SETUP  = 3'd1,
        ST_A_STROBE = 3'd2,
        ST_D_SETUP  = 3'd3,
        ST_D_STROBE = 3'd4,
        ST_RELEASE  = 3'd5
    } step_e;

    // Request captured from the host when an access is accepted
    typedef struct packed {
        logic                 is_wr;
        logic [MXB_BUS_W-1:0] addr;
        logic [MXB_BUS_W-1:0] wdata;
    } xfer_t;

    function automatic step_e step_next(input step_e s, input logic start);
        case (s)
            ST_IDLE:     return start ? ST_A_SETUP : ST_IDLE;
            ST_A_SETUP:  return ST_A_STROBE;
            ST_A_STROBE: return ST_D_SETUP;
            ST_D_SETUP:  return ST_D_STROBE;
            ST_D_STROBE: return ST_RELEASE;
            default:     return ST_IDLE;
        endcase
    endfunction

    function automatic pmode_e step_mode(input step_e s, input logic is_wr);
        case (s)
            ST_A_SETUP, ST_A_STROBE: return PM_ADDR;
            ST_D_SETUP, ST_D_STROBE: return is_wr ? PM_WRITE : PM_READ;
            default:                 return PM_IDLE;
        endcase
    endfunction

    function automatic logic step_is_strobe(input step_e s);
        return (s == ST_A_STROBE) || (s == ST_D_STROBE);
    endfunction

    function automatic logic step_is_busy(input step_e s);
        return (s != ST_IDLE) && (s != ST_RELEASE);
    endfunction

endpackage

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
    import mxb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output step_e step,
    output logic  accept
);

    step_e step_q;

    assign accept = (step_q == ST_IDLE) && start;
    assign step   = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_IDLE;
        end else begin
            step_q <= step_next(step_q, start);
        end
    end

endmodule

// File: rtl/mxb_hold.sv
module mxb_hold
    import mxb_pkg::*;
#(
    parameter int unsigned BUS_W = MXB_BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  step_e            step,
    input  logic             host_wr,
    input  logic [BUS_W-1:0] host_addr,
    input  logic [BUS_W-1:0] host_wdata,
    input  logic [BUS_W-1:0] pin_in,
    output xfer_t            cur,
    output logic [BUS_W-1:0] rdata
);

    xfer_t            cur_q;
    logic [BUS_W-1:0] rdata_q;
    logic             capture;

    // The read sample is taken at the edge that closes the read strobe cycle
    assign capture = (step == ST_D_STROBE) && !cur_q.is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                cur_q.is_wr <= host_wr;
                cur_q.addr  <= host_addr;
                cur_q.wdata <= host_wdata;
            end
            if (capture) begin
                rdata_q <= pin_in;
            end
        end
    end

    assign cur   = cur_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/mxb_pins.sv
module mxb_pins
    import mxb_pkg::*;
#(
    parameter int unsigned BUS_W = MXB_BUS_W
) (
    input  step_e            step,
    input  xfer_t            cur,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    output logic [1:0]       mode,
    output logic             pclk
);

    pmode_e m;

    always_comb begin
        m      = step_mode(step, cur.is_wr);
        mode   = m;
        pclk   = step_is_strobe(step);
        ad_oe  = (m == PM_ADDR) || (m == PM_WRITE);
        ad_out = '0;
        if (m == PM_ADDR) begin
            ad_out = cur.addr;
        end else if (m == PM_WRITE) begin
            ad_out = cur.wdata;
        end
    end

endmodule

// File: rtl/mxb_bridge.sv
module mxb_bridge
    import mxb_pkg::*;
#(
    parameter int unsigned BUS_W = MXB_BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_cs,
    input  logic             h_rd,
    input  logic             h_wr,
    input  logic [BUS_W-1:0] h_addr,
    input  logic [BUS_W-1:0] h_wdata,
    output logic [BUS_W-1:0] h_rdata,
    output logic             h_wait,
    output logic [BUS_W-1:0] p_ad_out,
    output logic             p_ad_oe,
    input  logic [BUS_W-1:0] p_ad_in,
    output logic [1:0]       p_mode,
    output logic             p_clk
);

    step_e step;
    logic  start;
    logic  accept;
    xfer_t cur;

    assign start  = h_cs && (h_rd || h_wr);
    assign h_wait = step_is_busy(step) || accept;

    mxb_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .step   (step),
        .accept (accept)
    );

    mxb_hold #(.BUS_W(BUS_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .step       (step),
        .host_wr    (h_wr),
        .host_addr  (h_addr),
        .host_wdata (h_wdata),
        .pin_in     (p_ad_in),
        .cur        (cur),
        .rdata      (h_rdata)
    );

    mxb_pins #(.BUS_W(BUS_W)) u_pins (
        .step   (step),
        .cur    (cur),
        .ad_out (p_ad_out),
        .ad_oe  (p_ad_oe),
        .mode   (p_mode),
        .pclk   (p_clk)
    );

endmodule

// File: rtl/mxb_bridge_chk.sv
module mxb_bridge_chk #(
    parameter int unsigned BUS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             h_wait,
    input logic [BUS_W-1:0] h_rdata,
    input logic [BUS_W-1:0] p_ad_out,
    input logic             p_ad_oe,
    input logic [1:0]       p_mode,
    input logic             p_clk
);

    // R1: first cycle after reset is idle with the pins released
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (p_mode == 2'b00 && !p_ad_oe && !p_clk && h_rdata == '0));

    // R2: any active port mode implies the host is stalled
    a_r2_wait_while_active: assert property (@(posedge clk) disable iff (rst)
        (p_mode != 2'b00) |-> h_wait);

    // R2: wait drops only right after a strobe cycle
    a_r2_wait_falls_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(h_wait) |-> $past(p_clk));

    // R3 and R4: pins are enabled only in the address and write modes
    a_r3_oe_only_when_driving: assert property (@(posedge clk) disable iff (rst)
        p_ad_oe |-> (p_mode == 2'b01 || p_mode == 2'b11));

    // R5: pins released during a read
    a_r5_released_in_read: assert property (@(posedge clk) disable iff (rst)
        (p_mode == 2'b10) |-> !p_ad_oe);

    // R8: strobe lasts one cycle
    a_r8_single_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
        p_clk |=> !p_clk);

    // R8: strobe only with an active mode
    a_r8_pulse_needs_mode: assert property (@(posedge clk) disable iff (rst)
        p_clk |-> (p_mode != 2'b00));

    // R8: mode and pin value settled one cycle before the rising strobe
    a_r8_setup_before_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(p_clk) |-> ($stable(p_mode) && $stable(p_ad_out)));

endmodule

bind mxb_bridge mxb_bridge_chk #(.BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .h_wait   (h_wait),
    .h_rdata  (h_rdata),
    .p_ad_out (p_ad_out),
    .p_ad_oe  (p_ad_oe),
    .p_mode   (p_mode),
    .p_clk    (p_clk)
);

// File: tb/mxb_bridge_tb.sv
module mxb_bridge_tb;

    localparam int W = 8;

    typedef struct {
        bit         is_wr;
        logic [W-1:0] data;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         h_cs = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
    logic [W-1:0] h_addr = '0, h_wdata = '0;
    logic [W-1:0] h_rdata;
    logic         h_wait;
    logic [W-1:0] p_ad_out;
    logic         p_ad_oe;
    logic [W-1:0] p_ad_in;
    logic [1:0]   p_mode;
    logic         p_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] ram [0:255];
    logic [W-1:0] shadow [0:255];
    logic [W-1:0] ram_addr = '0;
    logic [W-1:0] ram_q = '0;
    logic [W-1:0] exp_addr = '0, exp_data = '0;
    bit           addr_seen = 0;
    int           pulses = 0;
    exp_t         sb[$];
    logic [W-1:0] last_rd = '0;
    logic         prev_wait = 1'b0;

    always #10 clk = ~clk;

    mxb_bridge #(.BUS_W(W)) u_dut (
        .clk(clk), .rst(rst), .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_wait(h_wait),
        .p_ad_out(p_ad_out), .p_ad_oe(p_ad_oe), .p_ad_in(p_ad_in),
        .p_mode(p_mode), .p_clk(p_clk)
    );

    // Resolved shared pins: bridge drives, else the RAM drives in read mode
    assign p_ad_in = p_ad_oe ? p_ad_out : ((p_mode == 2'b10) ? ram_q : '0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = '0;
            shadow[i] = '0;
        end
    end

    // RAM-side model and pin monitor (R3, R4, R5)
    always @(posedge p_clk) begin
        pulses++;
        case (p_mode)
            2'b01: begin
                chk(p_ad_oe && p_ad_out == exp_addr, "R3 address on pins", p_ad_out, exp_addr);
                ram_addr = p_ad_out;
                addr_seen = 1;
            end
            2'b11: begin
                chk(addr_seen, "R3 address before write data", addr_seen, 1);
                chk(p_ad_oe && p_ad_out == exp_data, "R4 write data on pins", p_ad_out, exp_data);
                ram[ram_addr] = p_ad_out;
                addr_seen = 0;
            end
            2'b10: begin
                chk(addr_seen, "R3 address before read", addr_seen, 1);
                chk(!p_ad_oe, "R5 pins released in read", p_ad_oe, 0);
                ram_q = ram[ram_addr];
                addr_seen = 0;
            end
            default: chk(0, "R8 pulse with idle mode", p_mode, 1);
        endcase
    end

    // Scoreboard monitor: completes at the release cycle (R2, R5)
    always @(negedge clk) begin
        if (rst) begin
            prev_wait <= 1'b0;
            addr_seen = 0;
        end else begin
            if (prev_wait && !h_wait) begin
                if (sb.size() == 0) begin
                    chk(0, "R2 unexpected completion", 0, 1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (!e.is_wr) last_rd = e.data;
                    chk(h_rdata == last_rd, "R5 read data at release", h_rdata, last_rd);
                    chk(p_mode == 2'b00 && !p_clk, "R2 release cycle idle", p_mode, 0);
                end
            end
            prev_wait <= h_wait;
        end
    end

    task automatic access(input bit wr, input logic [W-1:0] a, input logic [W-1:0] d,
                          input bit perturb);
        int n;
        exp_t e;
        exp_addr = a;
        exp_data = d;
        e.is_wr = wr;
        e.data  = wr ? '0 : shadow[a];
        sb.push_back(e);
        if (wr) shadow[a] = d;
        @(posedge clk); #1;
        h_cs = 1; h_wr = wr; h_rd = !wr; h_addr = a; h_wdata = d;
        n = 0;
        forever begin
            @(negedge clk);
            if (!h_wait) break;
            n++;
            if (perturb && n == 2) begin
                // R7: scramble host inputs mid-access
                h_addr = ~a; h_wdata = ~d; h_wr = !wr; h_rd = wr;
            end
            if (n > 20) break;
        end
        chk(n == 5, "R2 wait cycles", n, 5);
        @(posedge clk); #1;
        h_cs = 0; h_rd = 0; h_wr = 0;
    endtask

    task automatic check_idle(input string req);
        chk(p_mode == 2'b00 && !p_ad_oe && !p_clk && !h_wait,
            req, {p_mode, p_ad_oe, p_clk, h_wait}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 idle in reset");
        chk(h_rdata == '0, "R1 read data zero", h_rdata, 0);
        @(posedge clk); #1; rst = 0;
        @(negedge clk);
        check_idle("R1 idle after reset");

        access(1, 8'h00, 8'h5A, 0);
        access(1, 8'hFF, 8'hA5, 0);
        access(1, 8'h37, 8'h3C, 0);
        access(0, 8'h00, '0, 0);
        access(0, 8'hFF, '0, 0);
        access(1, 8'h10, 8'h99, 0);
        chk(h_rdata == 8'hA5, "R5 read data held across write", h_rdata, 8'hA5);
        access(0, 8'h37, '0, 0);
        for (int i = 1; i < 12; i++) access(1, W'(i * 21), W'(i * 37 + 5), 0);
        for (int i = 1; i < 12; i++) access(0, W'(i * 21), '0, 0);

        // R7: host inputs changed while stalled
        access(1, 8'h44, 8'hC3, 1);
        access(0, 8'h44, '0, 1);
        access(0, 8'hBB, '0, 0);

        // R6: strobes without chip select
        begin
            int p0;
            bit saw_wait;
            p0 = pulses;
            saw_wait = 0;
            @(posedge clk); #1;
            h_rd = 1; h_wr = 1; h_addr = 8'h00; h_wdata = 8'h11;
            repeat (8) begin
                @(negedge clk);
                if (h_wait) saw_wait = 1;
            end
            chk(!saw_wait, "R6 no wait without select", saw_wait, 0);
            chk(pulses == p0, "R6 no port pulse without select", pulses - p0, 0);
            @(posedge clk); #1; h_rd = 0; h_wr = 0;
        end
        access(0, 8'h00, '0, 0);

        // R1: reset in the middle of an access
        exp_addr = 8'h22;
        @(posedge clk); #1;
        h_cs = 1; h_wr = 1; h_addr = 8'h22; h_wdata = 8'h77;
        repeat (2) @(negedge clk);
        chk(h_wait && p_mode == 2'b01, "R3 address phase under way", p_mode, 1);
        @(posedge clk); #1;
        rst = 1; h_cs = 0; h_wr = 0;
        @(posedge clk); #1;
        rst = 0;
        @(negedge clk);
        check_idle("R1 idle after mid-access reset");
        chk(h_rdata == '0, "R1 read data cleared", h_rdata, 0);
        last_rd = '0;
        repeat (3) @(negedge clk);
        check_idle("R1 stays idle");
        access(0, 8'h37, '0, 0);
        access(1, 8'h22, 8'h66, 0);
        access(0, 8'h22, '0, 0);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R2 all accesses completed", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule